// File: doc/BRIEF.md
# Packed Byte SIMD Min/Max Unit

This unit works on 32-bit words that each hold four signed 8-bit lanes. Every lane is handled on its own and all four are handled at once. A single lane compare decides, for each lane, whether the lane of A is less than or equal to the same lane of B. That one compare feeds four kinds of result. The first is a per-lane minimum or maximum. The second is the compare written as a 0x01/0x00 flag in each byte. The third is the compare written as a 0xFF/0x00 byte mask. The fourth is the min or max result with its four lanes sign-extended and added to a 32-bit accumulator.

The compare uses no subtractor. It takes the byte-wise unsigned half-sum of A and ~B. It XORs that half-sum with A ^ ~B. The top bit of each byte is then the lane's A ≤ B flag. Each request is taken on a valid strobe. Its result appears in an output register one clock later, together with an output valid flag.

Top module: `packed_minmax_unit`

## Requirements
- R1: With opcode 2'b00 and `pick_max` low, each result byte holds the signed minimum of the matching bytes of A and B. Byte i is bits 8i+7..8i.
- R2: With opcode 2'b00 and `pick_max` high, each result byte holds the signed maximum of the matching bytes of A and B.
- R3: With opcode 2'b01, each result byte is 0x01 where the signed A byte is less than or equal to the signed B byte, and 0x00 otherwise.
- R4: With opcode 2'b10, each result byte is 0xFF where the signed A byte is less than or equal to the signed B byte, and 0x00 otherwise.
- R5: With opcode 2'b11, the result is the accumulator plus the four min lanes (or max lanes when `pick_max` is high). Each lane is sign-extended to 32 bits first, and the sum wraps modulo 2^32.
- R6: When two lanes are equal, both min and max return that common value.
- R7: A request sampled with `in_valid` high at a rising edge gives `out_valid` high and its result right after the next rising edge. `out_valid` is low after any edge at which `in_valid` was low.
- R8: Synchronous active-high reset clears `result` and `out_valid` to zero. While `in_valid` is low, `result` holds its last value.
- R9: `acc_in` has no effect on opcodes 2'b00, 2'b01 and 2'b10. `pick_max` has no effect on opcodes 2'b01 and 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | 32 | Operand A, four signed bytes |
| op_b | input | 32 | Operand B, four signed bytes |
| acc_in | input | 32 | Accumulator for opcode 2'b11 |
| opcode | input | 2 | 00 min/max, 01 flag compare, 10 mask compare, 11 min/max with accumulate |
| pick_max | input | 1 | 0 selects min, 1 selects max |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 32 | Registered result |

## Verification
Every result is due exactly one rising edge after the edge that samples its request. The bench drives requests on falling edges and pushes the expected value into a queue at that moment. A monitor on later falling edges pops one entry each time `out_valid` is high, so a result that comes a cycle early or late misaligns the queue and is caught. Hold behaviour and the low `out_valid` after idle cycles are checked several falling edges after the last request, when no further result can be in flight.

// File: rtl/simd_mm_pkg.sv
package simd_mm_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;
    localparam int ACC_W  = 32;

    typedef enum logic [1:0] {
        OP_SEL    = 2'b00,
        OP_LEBOOL = 2'b01,
        OP_LEMASK = 2'b10,
        OP_SELACC = 2'b11
    } smm_op_e;

    typedef struct packed {
        logic [WORD_W-1:0] opa;
        logic [WORD_W-1:0] opb;
        logic [ACC_W-1:0]  acc;
        smm_op_e           op;
        logic              pick_max;
    } smm_req_t;

    typedef struct packed {
        logic [WORD_W-1:0] sel_word;
        logic [WORD_W-1:0] bool_word;
        logic [WORD_W-1:0] mask_word;
    } smm_lane_out_t;

    // word with only the lowest bit of every lane set
    function automatic logic [WORD_W-1:0] lane_lsbs();
        logic [WORD_W-1:0] w;
        w = '0;
        for (int i = 0; i < LANES; i++) w[i*LANE_W] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/smm_le_compare.sv
module smm_le_compare #(
    parameter int LANES  = simd_mm_pkg::LANES,
    parameter int LANE_W = simd_mm_pkg::LANE_W
) (
    input  logic [LANES*LANE_W-1:0] a,
    input  logic [LANES*LANE_W-1:0] b,
    output logic [LANES-1:0]        le
);
    localparam int W = LANES * LANE_W;

    logic [W-1:0] nb, hi_mask, half_sum, fold;

    assign nb       = ~b;
    // carry-free byte-wise half-sum: top lane bits are masked off before the add
    assign half_sum = (a & nb) + (((a ^ nb) >> 1) & ~hi_mask);
    assign fold     = half_sum ^ (a ^ nb);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign hi_mask[i*LANE_W +: LANE_W] = {1'b1, {(LANE_W-1){1'b0}}};
        assign le[i] = fold[i*LANE_W + LANE_W - 1];

        always_comb begin
            if (!$isunknown({a[i*LANE_W +: LANE_W], b[i*LANE_W +: LANE_W]})) begin
                // R1
                le_sign_chk: assert (le[i] ==
                    ($signed(a[i*LANE_W +: LANE_W]) <= $signed(b[i*LANE_W +: LANE_W])));
            end
        end
    end

endmodule

// File: rtl/smm_lane_select.sv
module smm_lane_select #(
    parameter int LANES  = simd_mm_pkg::LANES,
    parameter int LANE_W = simd_mm_pkg::LANE_W
) (
    input  logic [LANES*LANE_W-1:0] a,
    input  logic [LANES*LANE_W-1:0] b,
    input  logic [LANES-1:0]        le,
    input  logic                    pick_max,
    output logic [LANES*LANE_W-1:0] sel_word,
    output logic [LANES*LANE_W-1:0] bool_word,
    output logic [LANES*LANE_W-1:0] mask_word
);
    localparam int W = LANES * LANE_W;

    logic [W-1:0] pick_mask;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W:0] widened;
        assign bool_word[i*LANE_W +: LANE_W] = {{(LANE_W-1){1'b0}}, le[i]};
        // boolean times (2^LANE_W - 1): shift then subtract
        assign widened = ({{LANE_W{1'b0}}, le[i]} << LANE_W) - {{LANE_W{1'b0}}, le[i]};
        assign mask_word[i*LANE_W +: LANE_W] = widened[LANE_W-1:0];
    end

    assign pick_mask = pick_max ? ~mask_word : mask_word;
    assign sel_word  = (a & pick_mask) | (b & ~pick_mask);

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        always_comb begin
            if (!$isunknown({a, b, le, pick_max})) begin
                // R6
                lane_source_chk: assert (
                    sel_word[i*LANE_W +: LANE_W] == a[i*LANE_W +: LANE_W] ||
                    sel_word[i*LANE_W +: LANE_W] == b[i*LANE_W +: LANE_W]);
            end
        end
    end

endmodule

// File: rtl/smm_reduce.sv
module smm_reduce #(
    parameter int LANES  = simd_mm_pkg::LANES,
    parameter int LANE_W = simd_mm_pkg::LANE_W,
    parameter int ACC_W  = simd_mm_pkg::ACC_W
) (
    input  logic [LANES*LANE_W-1:0] lanes,
    input  logic [ACC_W-1:0]        acc,
    output logic [ACC_W-1:0]        sum
);
    localparam int EXT_W = ACC_W - LANE_W;

    logic [LANES-1:0][ACC_W-1:0] ext;

    for (genvar i = 0; i < LANES; i++) begin : g_ext
        assign ext[i] = {{EXT_W{lanes[i*LANE_W + LANE_W - 1]}}, lanes[i*LANE_W +: LANE_W]};
    end

    always_comb begin
        sum = acc;
        for (int i = 0; i < LANES; i++) sum = sum + ext[i];
    end

endmodule

// File: rtl/packed_minmax_unit.sv
module packed_minmax_unit
    import simd_mm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [ACC_W-1:0]  acc_in,
    input  logic [1:0]        opcode,
    input  logic              pick_max,
    output logic              out_valid,
    output logic [ACC_W-1:0]  result
);
    localparam logic [WORD_W-1:0] LSB_PAT = lane_lsbs();

    smm_req_t          req;
    smm_lane_out_t     lanes_o;
    logic [LANES-1:0]  le;
    logic [ACC_W-1:0]  acc_sum;
    logic [ACC_W-1:0]  nxt;

    assign req = '{opa: op_a, opb: op_b, acc: acc_in,
                   op: smm_op_e'(opcode), pick_max: pick_max};

    smm_le_compare #(.LANES(LANES), .LANE_W(LANE_W)) u_cmp (
        .a  (req.opa),
        .b  (req.opb),
        .le (le)
    );

    smm_lane_select #(.LANES(LANES), .LANE_W(LANE_W)) u_sel (
        .a         (req.opa),
        .b         (req.opb),
        .le        (le),
        .pick_max  (req.pick_max),
        .sel_word  (lanes_o.sel_word),
        .bool_word (lanes_o.bool_word),
        .mask_word (lanes_o.mask_word)
    );

    smm_reduce #(.LANES(LANES), .LANE_W(LANE_W), .ACC_W(ACC_W)) u_red (
        .lanes (lanes_o.sel_word),
        .acc   (req.acc),
        .sum   (acc_sum)
    );

    always_comb begin
        unique case (req.op)
            OP_SEL:    nxt = ACC_W'(lanes_o.sel_word);
            OP_LEBOOL: nxt = ACC_W'(lanes_o.bool_word);
            OP_LEMASK: nxt = ACC_W'(lanes_o.mask_word);
            default:   nxt = acc_sum;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= nxt;
        end
    end

    // R7
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid && !rst));

    // R3
    bool_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(opcode) == OP_LEBOOL) |-> ((result[WORD_W-1:0] & ~LSB_PAT) == '0));

    // R4
    mask_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(opcode) == OP_LEMASK) |->
            (result[WORD_W-1:0] == WORD_W'((result[WORD_W-1:0] & LSB_PAT) * 255)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(in_valid) && !$past(rst)) |-> $stable(result));

endmodule

// File: tb/tb_packed_minmax_unit.sv
`timescale 1ns/1ps
module tb_packed_minmax_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, acc_in = '0;
    logic [1:0]  opcode = 2'b00;
    logic        pick_max = 1'b0;
    logic        out_valid;
    logic [31:0] result;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t q[$];
    logic [31:0] last_val = '0;

    always #10 clk = ~clk;

    packed_minmax_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .acc_in(acc_in), .opcode(opcode), .pick_max(pick_max),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b,
                                          logic [31:0] acc, logic [1:0] op, logic mx);
        logic [31:0] sel_w, bool_w, mask_w, sum;
        sum = acc;
        for (int i = 0; i < 4; i++) begin
            int sa, sb, pick;
            sa = int'($signed(a[i*8 +: 8]));
            sb = int'($signed(b[i*8 +: 8]));
            pick = mx ? ((sa >= sb) ? sa : sb) : ((sa <= sb) ? sa : sb);
            sel_w[i*8 +: 8]  = 8'(pick);
            bool_w[i*8 +: 8] = (sa <= sb) ? 8'h01 : 8'h00;
            mask_w[i*8 +: 8] = (sa <= sb) ? 8'hFF : 8'h00;
            sum = sum + 32'(pick);
        end
        case (op)
            2'b00:   return sel_w;
            2'b01:   return bool_w;
            2'b10:   return mask_w;
            default: return sum;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send(logic [31:0] a, logic [31:0] b, logic [31:0] acc,
                        logic [1:0] op, logic mx, string tag);
        exp_t e;
        @(negedge clk);
        op_a = a; op_b = b; acc_in = acc; opcode = op; pick_max = mx;
        in_valid = 1'b1;
        e.val = model(a, b, acc, op, mx);
        e.tag = tag;
        q.push_back(e);
        last_val = e.val;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_a = 32'hDEAD_BEEF; op_b = 32'h1234_5678; acc_in = 32'h5555_AAAA;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q.size() == 0) begin
                tests++; fails++;
                $display("FAIL R7: actual out_valid 1 expected 0 (no request pending)");
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, result, e.val);
            end
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset out_valid", {31'b0, out_valid}, 32'd0);
        check("R8 reset result", result, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // R1 min, mixed signs
        send(32'h80_7F_05_FB, 32'h7F_80_FB_05, 32'h0, 2'b00, 1'b0, "R1 min mixed");
        // R2 max, same operands
        send(32'h80_7F_05_FB, 32'h7F_80_FB_05, 32'h0, 2'b00, 1'b1, "R2 max mixed");
        // R6 equal lanes
        send(32'h80_00_7F_C3, 32'h80_00_7F_C3, 32'h0, 2'b00, 1'b0, "R6 equal min");
        send(32'h80_00_7F_C3, 32'h80_00_7F_C3, 32'h0, 2'b00, 1'b1, "R6 equal max");
        // R3 flag compare, including equality
        send(32'h01_FF_80_10, 32'h01_00_7F_0F, 32'h0, 2'b01, 1'b0, "R3 flag compare");
        // R4 mask compare
        send(32'h01_FF_80_10, 32'h01_00_7F_0F, 32'h0, 2'b10, 1'b0, "R4 mask compare");
        // R5 accumulate with negative lanes
        send(32'h80_80_80_80, 32'h00_01_02_03, 32'd1000, 2'b11, 1'b0, "R5 acc min neg");
        send(32'h80_80_80_80, 32'h00_01_02_03, 32'd1000, 2'b11, 1'b1, "R5 acc max");
        // R5 wrap
        send(32'h7F_7F_7F_7F, 32'h7F_7F_7F_7F, 32'h7FFF_FFFF, 2'b11, 1'b0, "R5 acc wrap");
        // R9 acc and pick_max ignored
        send(32'h10_F0_33_CC, 32'h20_E0_33_DD, 32'hFFFF_0000, 2'b00, 1'b0, "R9 acc ignored min");
        send(32'h10_F0_33_CC, 32'h20_E0_33_DD, 32'h1234_5678, 2'b01, 1'b1, "R9 pick ignored flag");
        send(32'h10_F0_33_CC, 32'h20_E0_33_DD, 32'h0BAD_F00D, 2'b10, 1'b1, "R9 pick ignored mask");
        idle(3);

        // R7 / R8 after idle: no valid, result held
        check("R7 idle out_valid", {31'b0, out_valid}, 32'd0);
        check("R8 hold result", result, last_val);

        // varied patterns across every opcode
        for (int k = 0; k < 64; k++) begin
            logic [31:0] ra, rb, rc;
            ra = $urandom; rb = $urandom; rc = $urandom;
            if (k % 8 == 0) rb = ra;
            send(ra, rb, rc, 2'(k % 4), 1'((k / 4) % 2),
                 (k % 4 == 0) ? "R1 R2 loop" : (k % 4 == 1) ? "R3 loop" :
                 (k % 4 == 2) ? "R4 loop" : "R5 loop");
            if (k % 5 == 4) idle(1);
        end
        idle(3);
        check("R7 queue drained", 32'(q.size()), 32'd0);
        check("R8 final hold", result, last_val);

        // reset mid-stream clears state
        send(32'h01020304, 32'h05060708, 32'h0, 2'b00, 1'b0, "R8 pre-reset");
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        q.delete();
        @(negedge clk);
        check("R8 reset clears result", result, 32'd0);
        check("R8 reset clears valid", {31'b0, out_valid}, 32'd0);
        rst = 1'b0;
        idle(2);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule